// File: doc/BRIEF.md
# I2C EEPROM Boot Configuration Loader

This block runs once after reset, with no software involved. It pulls a fixed-length configuration image out of a serial EEPROM and turns that image into a series of 32-bit register writes. It talks to the EEPROM through a byte-level I2C master. Each command it issues (start, repeated start, write byte, read byte, stop) is held on `cmd_valid`/`cmd_op` until the master pulses `cmd_done`. With that pulse the master returns the slave's acknowledge on `rx_ack` and, for a read, the byte on `rx_data`.

The access is a random-address read. The block sends the device address for writing, then a 16-bit memory pointer with the high byte first, then a repeated start with the device address for reading, and then reads the whole image in sequence. From a fixed offset the image holds back-to-back 7-byte records. Each record carries a big-endian word address and big-endian 32-bit data. Each record becomes one transaction on a valid/ready write bus. The I2C read stream stalls until that transaction is accepted. Once the image is finished, the block reads a designated memory-controller configuration register, sets its enable bit, writes it back and raises `done`. If any address or pointer byte is not acknowledged, the block sends a stop and ends with `done` and `error` both high.

The controller moves through the following states.

- It starts in `S_WAIT_FREE` and goes to `S_START` once the bus is not busy.
- The address phase runs `S_START` → `S_DEV_WR` → `S_PTR_HI` → `S_PTR_LO` → `S_RESTART` → `S_DEV_RD` → `S_READ`. Each step follows a `cmd_done`. Any of the four address or pointer states moves instead to `S_ABORT` when the byte is NACKed.
- `S_READ` moves to `S_REG_WR` when a record's last data byte arrives, and to `S_STOP` after the final image byte.
- `S_REG_WR` returns to `S_READ` when the write is accepted. If the image is already finished, it goes to `S_STOP` instead.
- The closing sequence is `S_STOP` → `S_CTRL_RD` → `S_CTRL_WR` → `S_DONE`.
- `S_ABORT` → `S_FAIL`.
- `S_DONE` and `S_FAIL` hold until reset.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: After reset the block drives no I2C command while `bus_busy` is high. Its first command is START, issued only after `bus_busy` has been seen low.
- R2: The `cmd_op` encoding is START=0, RSTART=1, WRITE=2, READ=3, STOP=4. After START the block issues three WRITE commands in this order: 0xA0 (device 0x50 with the write bit), then pointer high byte 0x00, then pointer low byte 0x00.
- R3: After the pointer comes RSTART, then WRITE 0xA1, then exactly 135 READ commands. The first 134 have `cmd_nack`=0 and the last has `cmd_nack`=1. A STOP follows immediately.
- R4: Records start at image byte 18 and are 7 bytes long, giving 16 records (offsets 18 to 123). Image bytes 0–17, byte 6 of every record and bytes 130–134 have no effect on any write. Exactly 17 writes occur: 16 records and the final enable.
- R5: Record bytes 0 (high) and 1 (low) form a 16-bit word address. `wr_addr` is that value shifted left by 2, zero-extended to 32 bits.
- R6: Record bytes 2 to 5 form `wr_data` in big-endian order, with byte 2 in bits 31:24.
- R7: Each record produces one write transaction, in image order. `wr_addr`/`wr_data` stay stable while `wr_valid` is high and `wr_ready` is low. No I2C command is driven while a write or read is pending.
- R8: After the STOP the block reads address 0x2130 (`rd_valid`/`rd_ready`). It then writes address 0x2130 with the returned value ORed with bit 31.
- R9: At reset `cmd_valid`, `wr_valid`, `rd_valid`, `done` and `error` are low. `done` rises with `error` low after the enable write is accepted, and both hold until reset.
- R10: A NACK on any of the four address or pointer bytes (0xA0, pointer high, pointer low, 0xA1) is followed directly by STOP. The block then holds `done`=1 and `error`=1, with no register write and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | output | 1 | I2C command present |
| cmd_op | output | 3 | Command code (R2 encoding) |
| cmd_wdata | output | 8 | Byte for a WRITE command |
| cmd_nack | output | 1 | Reply NACK instead of ACK to this READ |
| cmd_done | input | 1 | One-cycle completion pulse for the current command |
| bus_busy | input | 1 | I2C bus occupied |
| rx_ack | input | 1 | Slave acknowledged the written byte (valid with `cmd_done`) |
| rx_data | input | 8 | Byte received by a READ (valid with `cmd_done`) |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | 32 | Register byte address |
| wr_data | output | 32 | Register write data |
| wr_ready | input | 1 | Write accepted |
| rd_valid | output | 1 | Register read request |
| rd_addr | output | 32 | Register read address |
| rd_data | input | 32 | Read data (valid with `rd_ready`) |
| rd_ready | input | 1 | Read completed |
| done | output | 1 | Sequence finished |
| error | output | 1 | Sequence aborted on a NACK |

## Verification
The assertions assume a well-behaved I2C master:

- It pulses `cmd_done` for a single cycle, only while `cmd_valid` is high, and returns `rx_ack` with that pulse.
- After each pulse it lets the new command settle for a cycle before acting on it.

They also assume the register bus raises `wr_ready` or `rd_ready` only against a pending request, and only for one cycle. The bench models both agents this way. Per run it varies the command latency, the write latency, the image contents, the control register's prior value and which address byte is NACKed.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_STOP   = 3'd4
    } i2c_op_e;

    typedef enum logic [3:0] {
        S_WAIT_FREE,
        S_START,
        S_DEV_WR,
        S_PTR_HI,
        S_PTR_LO,
        S_RESTART,
        S_DEV_RD,
        S_READ,
        S_REG_WR,
        S_STOP,
        S_CTRL_RD,
        S_CTRL_WR,
        S_DONE,
        S_ABORT,
        S_FAIL
    } ld_state_e;

endpackage

// File: rtl/cfgld_tracker.sv
// Counts received image bytes and assembles address/data records.
module cfgld_tracker #(
    parameter int IMAGE_LEN  = 135,
    parameter int REC_OFFSET = 18,
    parameter int REC_LEN    = 7,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [7:0]        byte_in,
    output logic              rec_hit,
    output logic              image_end,
    output logic              next_last,
    output logic              all_rx,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data
);
    localparam int NUM_REC = (IMAGE_LEN - REC_OFFSET) / REC_LEN;
    localparam int IDX_W   = $clog2(IMAGE_LEN + 1);
    localparam int REC_W   = $clog2(NUM_REC + 1);
    localparam int SLOT_W  = $clog2(REC_LEN);
    localparam int DBYTES  = DATA_W / 8;

    localparam logic [IDX_W-1:0]  IDX_FIRST = IDX_W'(REC_OFFSET);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(IMAGE_LEN - 1);
    localparam logic [IDX_W-1:0]  IDX_END   = IDX_W'(IMAGE_LEN);
    localparam logic [REC_W-1:0]  REC_MAX   = REC_W'(NUM_REC);
    localparam logic [SLOT_W-1:0] SLOT_AHI  = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] SLOT_ALO  = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_D0   = SLOT_W'(2);
    localparam logic [SLOT_W-1:0] SLOT_DL   = SLOT_W'(1 + DBYTES);
    localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(REC_LEN - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [REC_W-1:0]  rec_q;
    logic [SLOT_W-1:0] slot_q;
    logic [15:0]       word_q;
    logic [DATA_W-1:0] data_q;
    logic              in_region;

    assign in_region = (idx_q >= IDX_FIRST) && (rec_q < REC_MAX);
    assign rec_hit   = byte_stb && in_region && (slot_q == SLOT_DL);
    assign image_end = byte_stb && (idx_q == IDX_LAST);
    assign next_last = (idx_q == IDX_LAST);
    assign all_rx    = (idx_q == IDX_END);
    assign rec_addr  = ADDR_W'({word_q, 2'b00});
    assign rec_data  = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            rec_q  <= '0;
            slot_q <= '0;
            word_q <= '0;
            data_q <= '0;
        end else if (byte_stb) begin
            idx_q <= idx_q + 1'b1;
            if (in_region) begin
                if (slot_q == SLOT_AHI) begin
                    word_q[15:8] <= byte_in;
                end else if (slot_q == SLOT_ALO) begin
                    word_q[7:0] <= byte_in;
                end else if (slot_q >= SLOT_D0 && slot_q <= SLOT_DL) begin
                    data_q <= {data_q[DATA_W-9:0], byte_in};
                end
                if (slot_q == SLOT_END) begin
                    slot_q <= '0;
                    rec_q  <= rec_q + 1'b1;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfgld_rmw.sv
// Captures the control register value and sets its enable bit.
module cfgld_rmw #(
    parameter int DATA_W = 32,
    parameter int EN_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] rd_value,
    output logic [DATA_W-1:0] wb_value
);
    localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << EN_BIT;

    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (cap) begin
            hold_q <= rd_value;
        end
    end

    assign wb_value = hold_q | EN_MASK;
endmodule

// File: rtl/cfgld_fsm.sv
// Sequencing state machine for the boot loader.
module cfgld_fsm
    import cfgld_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h50,
    parameter logic [15:0] MEM_PTR  = 16'h0000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_done,
    input  logic      bus_busy,
    input  logic      rx_ack,
    input  logic      rec_hit,
    input  logic      image_end,
    input  logic      all_rx,
    input  logic      wr_ready,
    input  logic      rd_ready,
    output logic      cmd_valid,
    output i2c_op_e   cmd_op,
    output logic [7:0] cmd_wdata,
    output logic      byte_stb,
    output logic      wr_valid,
    output logic      sel_ctrl,
    output logic      rd_valid,
    output logic      done,
    output logic      error
);
    ld_state_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_WAIT_FREE;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_WAIT_FREE: if (!bus_busy) nxt = S_START;
            S_START:     if (cmd_done) nxt = S_DEV_WR;
            S_DEV_WR:    if (cmd_done) nxt = rx_ack ? S_PTR_HI : S_ABORT;
            S_PTR_HI:    if (cmd_done) nxt = rx_ack ? S_PTR_LO : S_ABORT;
            S_PTR_LO:    if (cmd_done) nxt = rx_ack ? S_RESTART : S_ABORT;
            S_RESTART:   if (cmd_done) nxt = S_DEV_RD;
            S_DEV_RD:    if (cmd_done) nxt = rx_ack ? S_READ : S_ABORT;
            S_READ: begin
                if (cmd_done) begin
                    if (rec_hit) begin
                        nxt = S_REG_WR;
                    end else if (image_end) begin
                        nxt = S_STOP;
                    end
                end
            end
            S_REG_WR:    if (wr_ready) nxt = all_rx ? S_STOP : S_READ;
            S_STOP:      if (cmd_done) nxt = S_CTRL_RD;
            S_CTRL_RD:   if (rd_ready) nxt = S_CTRL_WR;
            S_CTRL_WR:   if (wr_ready) nxt = S_DONE;
            S_ABORT:     if (cmd_done) nxt = S_FAIL;
            S_DONE:      nxt = S_DONE;
            S_FAIL:      nxt = S_FAIL;
            default:     nxt = S_WAIT_FREE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_START;
        cmd_wdata = 8'h00;
        wr_valid  = 1'b0;
        sel_ctrl  = 1'b0;
        rd_valid  = 1'b0;
        done      = 1'b0;
        error     = 1'b0;
        unique case (st)
            S_START: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_START;
            end
            S_DEV_WR: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_wdata = {DEV_ADDR, 1'b0};
            end
            S_PTR_HI: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_wdata = MEM_PTR[15:8];
            end
            S_PTR_LO: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_wdata = MEM_PTR[7:0];
            end
            S_RESTART: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_RSTART;
            end
            S_DEV_RD: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_wdata = {DEV_ADDR, 1'b1};
            end
            S_READ: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_READ;
            end
            S_REG_WR: wr_valid = 1'b1;
            S_STOP, S_ABORT: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_STOP;
            end
            S_CTRL_RD: rd_valid = 1'b1;
            S_CTRL_WR: begin
                wr_valid = 1'b1;
                sel_ctrl = 1'b1;
            end
            S_DONE: done = 1'b1;
            S_FAIL: begin
                done  = 1'b1;
                error = 1'b1;
            end
            default: ;
        endcase
    end

    assign byte_stb = (st == S_READ) && cmd_done;
endmodule

// File: rtl/eeprom_cfg_loader.sv
// Top level: I2C EEPROM boot configuration loader.
module eeprom_cfg_loader #(
    parameter logic [6:0]  DEV_ADDR   = 7'h50,
    parameter logic [15:0] MEM_PTR    = 16'h0000,
    parameter int          IMAGE_LEN  = 135,
    parameter int          REC_OFFSET = 18,
    parameter int          REC_LEN    = 7,
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] CTRL_ADDR  = 32'h0000_2130,
    parameter int          EN_BIT     = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [7:0]        cmd_wdata,
    output logic              cmd_nack,
    input  logic              cmd_done,
    input  logic              bus_busy,
    input  logic              rx_ack,
    input  logic [7:0]        rx_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_ready,
    output logic              done,
    output logic              error
);
    import cfgld_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    i2c_op_e           op_e;
    logic              byte_stb, rec_hit, image_end, next_last, all_rx, sel_ctrl;
    logic [ADDR_W-1:0] rec_addr;
    logic [DATA_W-1:0] rec_data, wb_value;

    cfgld_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .MEM_PTR  (MEM_PTR)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_done  (cmd_done),
        .bus_busy  (bus_busy),
        .rx_ack    (rx_ack),
        .rec_hit   (rec_hit),
        .image_end (image_end),
        .all_rx    (all_rx),
        .wr_ready  (wr_ready),
        .rd_ready  (rd_ready),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_e),
        .cmd_wdata (cmd_wdata),
        .byte_stb  (byte_stb),
        .wr_valid  (wr_valid),
        .sel_ctrl  (sel_ctrl),
        .rd_valid  (rd_valid),
        .done      (done),
        .error     (error)
    );

    cfgld_tracker #(
        .IMAGE_LEN  (IMAGE_LEN),
        .REC_OFFSET (REC_OFFSET),
        .REC_LEN    (REC_LEN),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W)
    ) i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_stb  (byte_stb),
        .byte_in   (rx_data),
        .rec_hit   (rec_hit),
        .image_end (image_end),
        .next_last (next_last),
        .all_rx    (all_rx),
        .rec_addr  (rec_addr),
        .rec_data  (rec_data)
    );

    cfgld_rmw #(
        .DATA_W (DATA_W),
        .EN_BIT (EN_BIT)
    ) i_rmw (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (rd_valid && rd_ready),
        .rd_value (rd_data),
        .wb_value (wb_value)
    );

    assign cmd_op   = op_e;
    assign cmd_nack = (op_e == OP_READ) && next_last;
    assign wr_addr  = sel_ctrl ? CTRL_A : rec_addr;
    assign wr_data  = sel_ctrl ? wb_value : rec_data;
    assign rd_addr  = CTRL_A;
endmodule

// File: rtl/cfgld_checker.sv
// Temporal checks for eeprom_cfg_loader, attached by bind.
module cfgld_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic          cmd_nack,
    input logic          cmd_done,
    input logic          bus_busy,
    input logic          rx_ack,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          rd_valid,
    input logic          done,
    input logic          error
);
    import cfgld_pkg::*;

    assert_start_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_START && !$past(cmd_valid)) |-> !$past(bus_busy));

    assert_nack_then_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ && cmd_nack && cmd_done)
        |=> (cmd_valid && cmd_op == OP_STOP));

    assert_write_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    assert_no_cmd_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || rd_valid) |-> !cmd_valid);

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(error)));

    assert_abort_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRITE && cmd_done && !rx_ack)
        |=> (cmd_valid && cmd_op == OP_STOP));

    assert_error_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (done && !wr_valid && !rd_valid && !cmd_valid));
endmodule

bind eeprom_cfg_loader cfgld_checker #(.AW(ADDR_W), .DW(DATA_W)) i_cfgld_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_nack  (cmd_nack),
    .cmd_done  (cmd_done),
    .bus_busy  (bus_busy),
    .rx_ack    (rx_ack),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .done      (done),
    .error     (error)
);

// File: tb/test_eeprom_cfg_loader.sv
module test_eeprom_cfg_loader;
    localparam int IMG = 135;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid, cmd_nack, cmd_done, bus_busy, rx_ack;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_wdata, rx_data;
    logic        wr_valid, wr_ready, rd_valid, rd_ready, done, error;
    logic [31:0] wr_addr, wr_data, rd_addr, rd_data;

    always #2 clk = ~clk;

    eeprom_cfg_loader i_eeprom_cfg_loader (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .cmd_done(cmd_done),
        .bus_busy(bus_busy), .rx_ack(rx_ack), .rx_data(rx_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
        .done(done), .error(error)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0]  img [0:IMG-1];
    int clat, wlat, nack_at;
    logic [31:0] ctrl_val;
    logic [2:0]  lop [0:199];
    logic [7:0]  lwd [0:199];
    logic        lnk [0:199];
    logic [31:0] laddr [0:31];
    logic [31:0] ldata [0:31];
    logic        lstab [0:31];
    logic [31:0] lrda, fa, fd;
    int n_cmd, n_wr, n_rd, busy_viol, cctr, wctr, wbyte, rbyte;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // I2C master and register bus responders, all on the falling edge
    initial begin
        cmd_done = 0; rx_ack = 0; rx_data = 0; wr_ready = 0; rd_ready = 0; rd_data = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                cmd_done = 0; wr_ready = 0; rd_ready = 0; cctr = 0; wctr = 0;
                n_cmd = 0; n_wr = 0; n_rd = 0; wbyte = 0; rbyte = 0; busy_viol = 0;
            end else begin
                if (cmd_valid && bus_busy) busy_viol++;
                if (cmd_done) begin
                    cmd_done = 0;
                end else if (cmd_valid) begin
                    if (cctr >= clat) begin
                        cctr = 0;
                        cmd_done = 1;
                        if (n_cmd < 200) begin
                            lop[n_cmd] = cmd_op; lwd[n_cmd] = cmd_wdata; lnk[n_cmd] = cmd_nack;
                        end
                        n_cmd++;
                        if (cmd_op == 3'd2) begin
                            rx_ack = (wbyte != nack_at);
                            wbyte++;
                        end
                        if (cmd_op == 3'd3) begin
                            rx_data = (rbyte < IMG) ? img[rbyte] : 8'h00;
                            rbyte++;
                        end
                    end else begin
                        cctr++;
                    end
                end
                if (wr_ready) begin
                    wr_ready = 0;
                end else if (wr_valid) begin
                    if (wctr == 0) begin fa = wr_addr; fd = wr_data; end
                    if (wctr >= wlat) begin
                        wr_ready = 1;
                        wctr = 0;
                        if (n_wr < 32) begin
                            laddr[n_wr] = wr_addr; ldata[n_wr] = wr_data;
                            lstab[n_wr] = (wr_addr == fa) && (wr_data == fd);
                        end
                        n_wr++;
                    end else begin
                        wctr++;
                    end
                end
                if (rd_ready) begin
                    rd_ready = 0;
                end else if (rd_valid) begin
                    rd_ready = 1;
                    rd_data = ctrl_val;
                    lrda = rd_addr;
                    n_rd++;
                end
            end
        end
    end

    task automatic run(input logic [7:0] seed, input int mul, input int cl, input int wl,
                       input int nk, input logic [31:0] cv);
        int n_exp, wpos;
        logic [2:0] eop [0:199];
        logic [7:0] ewd [0:199];
        logic       enk [0:199];
        for (int i = 0; i < IMG; i++) img[i] = 8'((i * mul) + seed);
        clat = cl; wlat = wl; nack_at = nk; ctrl_val = cv;
        @(negedge clk);
        rst_n = 0; bus_busy = 1;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset cmd_valid", 32'(cmd_valid), 0);
        chk("R9", "reset wr_valid", 32'(wr_valid), 0);
        chk("R9", "reset done", 32'(done), 0);
        chk("R9", "reset error", 32'(error), 0);
        rst_n = 1;
        repeat (20) @(negedge clk);
        // R1: still nothing issued while busy
        chk("R1", "cmd_valid while busy", 32'(cmd_valid), 0);
        bus_busy = 0;
        begin : wait_done
            int c;
            for (c = 0; c < 20000 && !done; c++) @(negedge clk);
            if (!done) chk("R9", "watchdog expired", 0, 1);
        end
        repeat (6) @(negedge clk);
        chk("R9", "done held", 32'(done), 1);
        chk("R1", "commands while busy", 32'(busy_viol), 0);

        // expected I2C command sequence
        eop[0] = 3'd0; ewd[0] = 0; enk[0] = 0;
        eop[1] = 3'd2; ewd[1] = 8'hA0; enk[1] = 0;
        eop[2] = 3'd2; ewd[2] = 8'h00; enk[2] = 0;
        eop[3] = 3'd2; ewd[3] = 8'h00; enk[3] = 0;
        eop[4] = 3'd1; ewd[4] = 0; enk[4] = 0;
        eop[5] = 3'd2; ewd[5] = 8'hA1; enk[5] = 0;
        for (int i = 0; i < IMG; i++) begin
            eop[6+i] = 3'd3; ewd[6+i] = 0; enk[6+i] = (i == IMG-1);
        end
        eop[6+IMG] = 3'd4; ewd[6+IMG] = 0; enk[6+IMG] = 0;
        n_exp = 7 + IMG;
        if (nk >= 0) begin
            wpos = (nk == 3) ? 5 : nk + 1;
            eop[wpos+1] = 3'd4;
            n_exp = wpos + 2;
        end
        chk(nk >= 0 ? "R10" : "R3", "command count", 32'(n_cmd), 32'(n_exp));
        for (int i = 0; i < n_exp && i < n_cmd; i++) begin
            string rq;
            rq = (nk >= 0) ? "R10" : (i == 0) ? "R1" : (i < 4) ? "R2" : "R3";
            chk(rq, $sformatf("op[%0d]", i), 32'(lop[i]), 32'(eop[i]));
            if (eop[i] == 3'd2) chk(rq, $sformatf("wdata[%0d]", i), 32'(lwd[i]), 32'(ewd[i]));
            if (eop[i] == 3'd3) chk(rq, $sformatf("nack[%0d]", i), 32'(lnk[i]), 32'(enk[i]));
        end

        if (nk >= 0) begin
            chk("R10", "error", 32'(error), 1);
            chk("R10", "register writes", 32'(n_wr), 0);
            chk("R10", "register reads", 32'(n_rd), 0);
        end else begin
            chk("R9", "error", 32'(error), 0);
            chk("R4", "write count", 32'(n_wr), 17);
            for (int r = 0; r < 16 && r < n_wr; r++) begin
                int b;
                b = 18 + 7 * r;
                chk("R5", $sformatf("addr rec %0d", r), laddr[r],
                    {14'd0, img[b], img[b+1], 2'b00});
                chk("R6", $sformatf("data rec %0d", r), ldata[r],
                    {img[b+2], img[b+3], img[b+4], img[b+5]});
                chk("R7", $sformatf("stable rec %0d", r), 32'(lstab[r]), 1);
            end
            chk("R8", "read count", 32'(n_rd), 1);
            chk("R8", "read addr", lrda, 32'h2130);
            if (n_wr >= 17) begin
                chk("R8", "enable addr", laddr[16], 32'h2130);
                chk("R8", "enable data", ldata[16], cv | 32'h8000_0000);
            end
        end
    endtask

    initial begin
        bus_busy = 1;
        run(8'h11, 37, 0, 0, -1, 32'h0000_0004);
        run(8'hA5, 91, 1, 2, -1, 32'h8000_0001);
        run(8'h3C, 13, 3, 5, -1, 32'hFFFF_0000);
        run(8'h00,  1, 2, 1, -1, 32'h0000_0000);
        for (int k = 0; k < 4; k++) run(8'(k * 17), 7, 1, 1, k, 32'h1234_5678);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule